// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fetches start-up configuration from a small 3-wire serial EEPROM. The EEPROM is organised as 256 or 512 bytes and is addressed with 9 bits. After a synchronous reset the loader reads the byte at address 0 before anything else. If that byte holds the signature 0xA5, it reads the configuration bytes one READ command at a time and stores them in a register file. The register file drives a 48-bit MAC address, two Ethernet polling-interval bytes and 26 hub configuration bytes. If the signature is wrong, the EEPROM is treated as blank or absent, and the loader writes hardware defaults into the same registers instead.

The reset cause picks which registers a load touches. A load can be requested later through a one-cycle request with a kind code:
- A complete load covers the Ethernet and hub fields.
- A MAC-only load covers the six address bytes.
- An Ethernet load covers the MAC address and the polling bytes.

`busy_o` stays high until the last register of the selected set is written. The surrounding logic uses it to refuse host transactions. `valid_o` reports whether the most recent load found a good signature.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is held and in the first cycle after it: `busy_o` is 1, `valid_o` is 0, chip select is 0, and every register holds its hardware default (MAC 0, hub byte at offset 20h = 24h, offset 23h = 95h). A complete load then starts without a request.
- R2: Each byte is fetched with its own command. Chip select goes high, and the loader sends a 1, then opcode bits 1,0, then the 9-bit address MSB first. It then clocks one dummy bit and 8 data bits, MSB first, sampling data in on the rising serial clock. Data out never changes while the serial clock is high.
- R3: The serial clock spends exactly SK_HALF system clocks in each phase. Chip select stays low for at least 2*SK_HALF system clocks between two commands.
- R4: Every load first reads address 0. Loading continues only if that byte equals 0xA5.
- R5: EEPROM addresses 1..6 form the MAC address with the lowest address least significant: `mac_addr_o[7:0]` comes from address 1 and `mac_addr_o[47:40]` from address 6.
- R6: Kind 00 (complete) reads the following, in ascending address order, and leaves all three outputs updated:
  - addresses 1..8, where `eth_poll_o[7:0]` comes from address 7 and `eth_poll_o[15:8]` from address 8;
  - offsets 20h..39h, where hub byte k (`hub_cfg_o[8k+7:8k]`) comes from offset 20h+k.
- R7: Kind 01 reads only addresses 0..6. The polling and hub outputs keep their previous values.
- R8: Kinds 10 and 11 read addresses 0..8. The hub output keeps its previous value.
- R9: With a bad signature, no further address is read. Every register of the selected set takes its default:
  - MAC and polling bytes are 0;
  - the hub bytes are 24h,04h,12h,95h at offsets 20h..23h, 9Bh at 26h, 18h at 27h, 02h at 29h, 01h at 2Ch and 2Eh, 32h at 30h, 03h at 37h, the DID_MSB_DFLT parameter at 25h, and 0 elsewhere;
  - registers outside the set keep their values.
- R10: An accepted request raises `busy_o` at the next clock edge. `busy_o` falls in the same cycle the final register update becomes visible. Requests made while busy are ignored, and the configuration outputs never change while `busy_o` is low.
- R11: `valid_o` changes only as `busy_o` falls. It becomes 1 after a load with a good signature and 0 after one with a bad signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; a complete load follows it |
| load_req_i | input | 1 | One-cycle load request, accepted only while idle |
| load_kind_i | input | 2 | 00 complete, 01 MAC only, 10/11 Ethernet fields |
| eep_cs_o | output | 1 | EEPROM chip select, active high |
| eep_sk_o | output | 1 | EEPROM serial clock |
| eep_di_o | output | 1 | Serial data to the EEPROM |
| eep_do_i | input | 1 | Serial data from the EEPROM |
| mac_addr_o | output | 48 | MAC address register |
| eth_poll_o | output | 16 | Polling intervals (full speed low byte, high speed high byte) |
| hub_cfg_o | output | 208 | Hub configuration bytes, offset 20h+k in byte k |
| busy_o | output | 1 | Load in progress; host transactions must be refused |
| valid_o | output | 1 | Last load found a valid signature |

## Verification
The assertions take for granted that the EEPROM changes its data line only after a falling serial-clock edge, so the bit seen at a rising edge is stable. They also assume load requests are single-cycle pulses on the system clock. The bench respects both assumptions:
- Its behavioural EEPROM drives the dummy bit right after the last address bit and moves to each following data bit on a falling edge.
- It raises requests for exactly one clock, one clock after an edge, including the one deliberately issued in the middle of a running load.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int ADDR_W     = 9;
  localparam int MAC_BYTES  = 6;
  localparam int ETH_BYTES  = 8;
  localparam int POLL_BYTES = ETH_BYTES - MAC_BYTES;
  localparam int HUB_BYTES  = 26;
  localparam int HUB_BASE   = 'h20;
  localparam int NUM_BYTES  = ETH_BYTES + HUB_BYTES;
  localparam int IDX_W      = $clog2(NUM_BYTES);
  localparam logic [7:0] SIG_BYTE = 8'hA5;

  typedef enum logic [1:0] {
    KIND_FULL = 2'b00,
    KIND_MAC  = 2'b01,
    KIND_ETH  = 2'b10,
    KIND_ETHB = 2'b11
  } load_kind_e;

  // Register-file index to EEPROM byte address: Ethernet bytes start at 1,
  // hub bytes start at HUB_BASE.
  function automatic logic [ADDR_W-1:0] idx_to_addr(input logic [IDX_W-1:0] idx);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'(idx);
    if (idx < IDX_W'(ETH_BYTES)) a = a + 1'b1;
    else a = a + ADDR_W'(HUB_BASE - ETH_BYTES);
    return a;
  endfunction

  // Every load kind covers a prefix of the index space.
  function automatic logic [IDX_W-1:0] last_idx(input load_kind_e k);
    case (k)
      KIND_FULL: return IDX_W'(NUM_BYTES - 1);
      KIND_MAC:  return IDX_W'(MAC_BYTES - 1);
      default:   return IDX_W'(ETH_BYTES - 1);
    endcase
  endfunction

  function automatic logic [7:0] default_byte(input logic [IDX_W-1:0] idx,
                                              input logic [7:0] did_msb);
    logic [7:0] v;
    v = 8'h00;
    if (idx >= IDX_W'(ETH_BYTES)) begin
      case (int'(idx) - ETH_BYTES + HUB_BASE)
        'h20: v = 8'h24;
        'h21: v = 8'h04;
        'h22: v = 8'h12;
        'h23: v = 8'h95;
        'h25: v = did_msb;
        'h26: v = 8'h9B;
        'h27: v = 8'h18;
        'h29: v = 8'h02;
        'h2C: v = 8'h01;
        'h2E: v = 8'h01;
        'h30: v = 8'h32;
        'h37: v = 8'h03;
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/eep_rd_engine.sv
module eep_rd_engine #(
  parameter int SK_HALF = 4,
  parameter int ADDR_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              done_o,
  output logic [7:0]        data_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  input  logic              do_i
);
  localparam int CMD_BITS = ADDR_W + 3;
  localparam int TOT_BITS = CMD_BITS + 1 + 8;
  localparam int HC_W     = (SK_HALF > 1) ? $clog2(SK_HALF) : 1;
  localparam int BIT_W    = $clog2(TOT_BITS);
  localparam int GAP_CYC  = 2 * SK_HALF;
  localparam int GAP_W    = $clog2(GAP_CYC);

  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_GAP} eng_st_e;

  eng_st_e              st;
  logic [HC_W-1:0]      hc;
  logic                 ph;
  logic [BIT_W-1:0]     bidx;
  logic [CMD_BITS-1:0]  sh;
  logic [7:0]           rx;
  logic [GAP_W-1:0]     gapc;

  assign data_o = rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= E_IDLE;
      hc     <= '0;
      ph     <= 1'b0;
      bidx   <= '0;
      sh     <= '0;
      rx     <= '0;
      gapc   <= '0;
      cs_o   <= 1'b0;
      sk_o   <= 1'b0;
      di_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        E_IDLE: begin
          if (go_i) begin
            // start bit is driven now; sh keeps the opcode and address bits
            sh   <= {2'b10, addr_i, 1'b0};
            di_o <= 1'b1;
            cs_o <= 1'b1;
            sk_o <= 1'b0;
            hc   <= '0;
            ph   <= 1'b0;
            bidx <= '0;
            st   <= E_SHIFT;
          end
        end
        E_SHIFT: begin
          if (hc == HC_W'(SK_HALF - 1)) begin
            hc <= '0;
            if (!ph) begin
              ph   <= 1'b1;
              sk_o <= 1'b1;
              if (bidx > BIT_W'(CMD_BITS)) rx <= {rx[6:0], do_i};
            end else begin
              ph   <= 1'b0;
              sk_o <= 1'b0;
              if (bidx == BIT_W'(TOT_BITS - 1)) begin
                cs_o <= 1'b0;
                di_o <= 1'b0;
                gapc <= '0;
                st   <= E_GAP;
              end else begin
                bidx <= bidx + 1'b1;
                di_o <= (bidx < BIT_W'(CMD_BITS - 1)) ? sh[CMD_BITS-1] : 1'b0;
                sh   <= sh << 1;
              end
            end
          end else begin
            hc <= hc + 1'b1;
          end
        end
        E_GAP: begin
          if (gapc == GAP_W'(GAP_CYC - 1)) begin
            done_o <= 1'b1;
            st     <= E_IDLE;
          end else begin
            gapc <= gapc + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfgld_pkg::*;
#(
  parameter logic [7:0] DID_MSB_DFLT = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [1:0]        kind_i,
  output logic              rd_go_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_done_i,
  input  logic [7:0]        rd_data_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [7:0]        wr_data_o,
  output logic              busy_o,
  output logic              valid_o
);
  typedef enum logic [2:0] {S_START, S_SIG, S_LOAD, S_DEF, S_FIN, S_IDLE} seq_st_e;

  seq_st_e          st;
  load_kind_e       kind;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last;
  logic             sig_ok;

  assign last = last_idx(kind);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_START;
      kind      <= KIND_FULL;
      idx       <= '0;
      sig_ok    <= 1'b0;
      busy_o    <= 1'b1;
      valid_o   <= 1'b0;
      rd_go_o   <= 1'b0;
      rd_addr_o <= '0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      rd_go_o <= 1'b0;
      wr_en_o <= 1'b0;
      case (st)
        S_START: begin
          rd_go_o   <= 1'b1;
          rd_addr_o <= '0;
          st        <= S_SIG;
        end
        S_SIG: begin
          if (rd_done_i) begin
            idx <= '0;
            if (rd_data_i == SIG_BYTE) begin
              sig_ok    <= 1'b1;
              rd_go_o   <= 1'b1;
              rd_addr_o <= idx_to_addr(IDX_W'(0));
              st        <= S_LOAD;
            end else begin
              sig_ok <= 1'b0;
              st     <= S_DEF;
            end
          end
        end
        S_LOAD: begin
          if (rd_done_i) begin
            wr_en_o   <= 1'b1;
            wr_idx_o  <= idx;
            wr_data_o <= rd_data_i;
            if (idx == last) begin
              st <= S_FIN;
            end else begin
              idx       <= idx + 1'b1;
              rd_go_o   <= 1'b1;
              rd_addr_o <= idx_to_addr(idx + 1'b1);
            end
          end
        end
        S_DEF: begin
          wr_en_o   <= 1'b1;
          wr_idx_o  <= idx;
          wr_data_o <= default_byte(idx, DID_MSB_DFLT);
          if (idx == last) st <= S_FIN;
          else idx <= idx + 1'b1;
        end
        S_FIN: begin
          busy_o  <= 1'b0;
          valid_o <= sig_ok;
          st      <= S_IDLE;
        end
        default: begin
          if (req_i) begin
            kind      <= load_kind_e'(kind_i);
            busy_o    <= 1'b1;
            rd_go_o   <= 1'b1;
            rd_addr_o <= '0;
            st        <= S_SIG;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfgld_pkg::*;
#(
  parameter logic [7:0] DID_MSB_DFLT = 8'h00
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we_i,
  input  logic [IDX_W-1:0]        widx_i,
  input  logic [7:0]              wdata_i,
  output logic [8*MAC_BYTES-1:0]  mac_o,
  output logic [8*POLL_BYTES-1:0] poll_o,
  output logic [8*HUB_BYTES-1:0]  hub_o
);
  logic [7:0] mem [NUM_BYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BYTES; i++) mem[i] <= default_byte(IDX_W'(i), DID_MSB_DFLT);
    end else if (we_i) begin
      mem[widx_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_mac
    assign mac_o[8*g +: 8] = mem[g];
  end
  for (genvar g = 0; g < POLL_BYTES; g++) begin : g_poll
    assign poll_o[8*g +: 8] = mem[MAC_BYTES + g];
  end
  for (genvar g = 0; g < HUB_BYTES; g++) begin : g_hub
    assign hub_o[8*g +: 8] = mem[ETH_BYTES + g];
  end
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
  import cfgld_pkg::*;
#(
  parameter int         SK_HALF      = 4,
  parameter logic [7:0] DID_MSB_DFLT = 8'h00
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_req_i,
  input  logic [1:0]              load_kind_i,
  output logic                    eep_cs_o,
  output logic                    eep_sk_o,
  output logic                    eep_di_o,
  input  logic                    eep_do_i,
  output logic [8*MAC_BYTES-1:0]  mac_addr_o,
  output logic [8*POLL_BYTES-1:0] eth_poll_o,
  output logic [8*HUB_BYTES-1:0]  hub_cfg_o,
  output logic                    busy_o,
  output logic                    valid_o
);
  logic              rd_go;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_done;
  logic [7:0]        rd_data;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [7:0]        wr_data;

  eep_rd_engine #(.SK_HALF(SK_HALF), .ADDR_W(ADDR_W)) u_eng (
    .clk    (clk),
    .rst    (rst),
    .go_i   (rd_go),
    .addr_i (rd_addr),
    .done_o (rd_done),
    .data_o (rd_data),
    .cs_o   (eep_cs_o),
    .sk_o   (eep_sk_o),
    .di_o   (eep_di_o),
    .do_i   (eep_do_i)
  );

  cfg_load_seq #(.DID_MSB_DFLT(DID_MSB_DFLT)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_i     (load_req_i),
    .kind_i    (load_kind_i),
    .rd_go_o   (rd_go),
    .rd_addr_o (rd_addr),
    .rd_done_i (rd_done),
    .rd_data_i (rd_data),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data),
    .busy_o    (busy_o),
    .valid_o   (valid_o)
  );

  cfg_regfile #(.DID_MSB_DFLT(DID_MSB_DFLT)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we_i    (wr_en),
    .widx_i  (wr_idx),
    .wdata_i (wr_data),
    .mac_o   (mac_addr_o),
    .poll_o  (eth_poll_o),
    .hub_o   (hub_cfg_o)
  );
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
  parameter int MW = 48,
  parameter int PW = 16,
  parameter int HW = 208
) (
  input logic          clk,
  input logic          rst,
  input logic          cs,
  input logic          sk,
  input logic          di,
  input logic          busy,
  input logic          valid,
  input logic [MW-1:0] mac,
  input logic [PW-1:0] poll,
  input logic [HW-1:0] hub
);
  // R1: the cycle after reset is released still reports busy
  a_r1_busy_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> busy);

  // R2: data toward the EEPROM holds while the serial clock is high
  a_r2_di_steady_sk_high: assert property (@(posedge clk) disable iff (rst)
    sk |-> $stable(di));

  // R3: no serial clock activity outside a selected command
  a_r3_sk_low_unselected: assert property (@(posedge clk) disable iff (rst)
    !cs |-> !sk);

  // R10: the EEPROM is only selected during a load
  a_r10_cs_only_busy: assert property (@(posedge clk) disable iff (rst)
    cs |-> busy);

  // R10: configuration frozen while idle
  a_r10_cfg_frozen_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> ($stable(mac) && $stable(poll) && $stable(hub)));

  // R11: valid moves only as busy falls
  a_r11_valid_with_busy_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(valid) |-> $fell(busy));
endmodule

bind cfg_eeprom_loader cfgld_checker #(
  .MW(48), .PW(16), .HW(208)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .cs    (eep_cs_o),
  .sk    (eep_sk_o),
  .di    (eep_di_o),
  .busy  (busy_o),
  .valid (valid_o),
  .mac   (mac_addr_o),
  .poll  (eth_poll_o),
  .hub   (hub_cfg_o)
);

// File: tb/sim_cfg_eeprom_loader.sv
module sim_cfg_eeprom_loader;
  localparam int CLK_PERIOD = 10;
  localparam int SKH        = 2;
  localparam int NB         = 34;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req = 1'b0;
  logic [1:0]   kind = 2'b00;
  logic         cs, sk, di;
  logic         do_r = 1'b0;
  logic [47:0]  mac;
  logic [15:0]  poll;
  logic [207:0] hub;
  logic         busy, valid;

  cfg_eeprom_loader #(.SK_HALF(SKH)) u0 (
    .clk(clk), .rst(rst), .load_req_i(req), .load_kind_i(kind),
    .eep_cs_o(cs), .eep_sk_o(sk), .eep_di_o(di), .eep_do_i(do_r),
    .mac_addr_o(mac), .eth_poll_o(poll), .hub_cfg_o(hub),
    .busy_o(busy), .valid_o(valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  logic [7:0] rom [0:511];
  logic [7:0] nxt_b [0:NB-1];
  logic [7:0] exp_b [0:NB-1];
  logic       nxt_v = 1'b0;
  logic       exp_v = 1'b0;
  int         got_q[$];
  int         want_q[$];

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int addr_of(input int i);
    return (i < 8) ? i + 1 : 'h20 + i - 8;
  endfunction

  function automatic logic [7:0] dflt(input int i);
    if (i < 8) return 8'h00;
    case (addr_of(i))
      'h20: return 8'h24;  'h21: return 8'h04;  'h22: return 8'h12;
      'h23: return 8'h95;  'h26: return 8'h9B;  'h27: return 8'h18;
      'h29: return 8'h02;  'h2C: return 8'h01;  'h2E: return 8'h01;
      'h30: return 8'h32;  'h37: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [47:0] pk_mac(input bit use_exp);
    logic [47:0] r;
    for (int i = 0; i < 6; i++) r[8*i +: 8] = use_exp ? exp_b[i] : nxt_b[i];
    return r;
  endfunction
  function automatic logic [15:0] pk_poll(input bit use_exp);
    logic [15:0] r;
    for (int i = 0; i < 2; i++) r[8*i +: 8] = use_exp ? exp_b[6+i] : nxt_b[6+i];
    return r;
  endfunction
  function automatic logic [207:0] pk_hub(input bit use_exp);
    logic [207:0] r;
    for (int i = 0; i < 26; i++) r[8*i +: 8] = use_exp ? exp_b[8+i] : nxt_b[8+i];
    return r;
  endfunction

  // ---------------- behavioural EEPROM ----------------
  int         bitn = 0;
  logic [11:0] cmd = '0;
  logic [7:0]  osh = '0;

  always @(posedge cs) bitn = 0;

  always @(posedge sk) begin
    if (cs) begin
      bitn++;
      if (bitn <= 12) cmd = {cmd[10:0], di};
      if (bitn == 12) begin
        chk(cmd[11:9] == 3'b110, "R2 start bit and READ opcode", 256'(cmd[11:9]), 256'(3'b110));
        got_q.push_back(int'(cmd[8:0]));
        osh  = rom[cmd[8:0]];
        do_r = 1'b0;
      end
    end
  end

  always @(negedge sk) begin
    if (cs && bitn >= 13 && bitn <= 20) begin
      do_r = osh[7];
      osh  = {osh[6:0], 1'b0};
    end
  end

  // ---------------- per-clock reference compare ----------------
  logic prev_cs = 1'b0;
  logic prev_sk = 1'b0;
  int   run     = 0;
  int   lowrun  = 100;

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (busy) begin
        for (int i = 0; i < NB; i++) exp_b[i] = nxt_b[i];
        exp_v = nxt_v;
      end else begin
        chk(mac == pk_mac(1'b1), "R10 idle compare mac", 256'(mac), 256'(pk_mac(1'b1)));
        chk(poll == pk_poll(1'b1), "R10 idle compare poll", 256'(poll), 256'(pk_poll(1'b1)));
        chk(hub == pk_hub(1'b1), "R10 idle compare hub", 256'(hub), 256'(pk_hub(1'b1)));
        chk(valid == exp_v, "R11 idle compare valid", 256'(valid), 256'(exp_v));
      end
      if (cs) begin
        if (!prev_cs) begin
          chk(lowrun >= 2*SKH, "R3 chip-select gap", 256'(lowrun), 256'(2*SKH));
          run = 1;
        end else if (sk != prev_sk) begin
          chk(run == SKH, "R3 serial clock phase length", 256'(run), 256'(SKH));
          run = 1;
        end else begin
          run++;
        end
        lowrun = 0;
      end else begin
        lowrun++;
      end
      prev_cs = cs;
      prev_sk = sk;
    end
  end

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R10 watchdog: busy never settled actual=%0d expected<150000", cycles);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic fill(input int seed);
    for (int a = 0; a < 512; a++) rom[a] = 8'((a * seed + 7 * seed + 3) & 255);
    rom[0] = 8'hA5;
  endtask

  task automatic predict(input logic [1:0] k);
    int last;
    want_q.delete();
    want_q.push_back(0);
    last = (k == 2'b00) ? 33 : (k == 2'b01) ? 5 : 7;
    for (int i = 0; i <= last; i++) begin
      if (rom[0] == 8'hA5) begin
        nxt_b[i] = rom[addr_of(i)];
        want_q.push_back(addr_of(i));
      end else begin
        nxt_b[i] = dflt(i);
      end
    end
    nxt_v = (rom[0] == 8'hA5);
  endtask

  task automatic launch(input logic [1:0] k);
    @(posedge clk); #1;
    predict(k);
    got_q.delete();
    req  = 1'b1;
    kind = k;
    @(posedge clk); #1;
    req = 1'b0;
    chk(busy === 1'b1, "R10 busy right after accepted request", 256'(busy), 256'(1));
  endtask

  task automatic wait_idle;
    while (busy !== 1'b0) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk(mac == pk_mac(1'b0), {tag, " mac"}, 256'(mac), 256'(pk_mac(1'b0)));
    chk(poll == pk_poll(1'b0), {tag, " poll"}, 256'(poll), 256'(pk_poll(1'b0)));
    chk(hub == pk_hub(1'b0), {tag, " hub"}, 256'(hub), 256'(pk_hub(1'b0)));
    chk(valid == nxt_v, {tag, " valid"}, 256'(valid), 256'(nxt_v));
  endtask

  task automatic check_addrs(input string tag);
    chk(got_q.size() == want_q.size(), {tag, " read count"}, 256'(got_q.size()), 256'(want_q.size()));
    for (int i = 0; i < want_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == want_q[i], {tag, " read address"}, 256'(got_q[i]), 256'(want_q[i]));
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin nxt_b[i] = dflt(i); exp_b[i] = dflt(i); end
    fill(3);
    predict(2'b00);
    got_q.delete();
    repeat (3) @(posedge clk);
    #1;
    chk(busy === 1'b1, "R1 busy in reset", 256'(busy), 256'(1));
    chk(valid === 1'b0, "R1 valid in reset", 256'(valid), 256'(0));
    chk(cs === 1'b0, "R1 chip select in reset", 256'(cs), 256'(0));
    chk(mac === 48'h0, "R1 mac default", 256'(mac), 256'(0));
    chk(hub[7:0] === 8'h24 && hub[31:24] === 8'h95, "R1 hub defaults",
        256'({hub[31:24], hub[7:0]}), 256'(16'h9524));
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(busy === 1'b1, "R1 busy after reset release", 256'(busy), 256'(1));

    // complete load after reset
    wait_idle();
    check_all("R6 complete load");
    check_addrs("R4 R6 complete load order");
    chk(mac[7:0] == rom[1] && mac[47:40] == rom[6], "R5 MAC byte order",
        256'({mac[47:40], mac[7:0]}), 256'({rom[6], rom[1]}));
    chk(valid === 1'b1, "R11 valid after good signature", 256'(valid), 256'(1));

    // MAC-only load
    fill(5);
    launch(2'b01);
    wait_idle();
    check_all("R7 MAC-only load");
    check_addrs("R7 MAC-only reads");

    // Ethernet load
    fill(9);
    launch(2'b10);
    wait_idle();
    check_all("R8 Ethernet load");
    check_addrs("R8 Ethernet reads");

    // complete load with a request arriving mid-way
    fill(11);
    launch(2'b00);
    repeat (50) @(posedge clk);
    #1;
    req = 1'b1; kind = 2'b01;
    @(posedge clk); #1;
    req = 1'b0;
    wait_idle();
    check_all("R10 request while busy ignored");
    check_addrs("R10 single load performed");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(busy === 1'b0, "R10 no queued load", 256'(busy), 256'(0));
    end

    // bad signature, Ethernet subset
    rom[0] = 8'hA4;
    launch(2'b10);
    wait_idle();
    check_all("R9 bad signature Ethernet subset");
    check_addrs("R9 only signature read");
    chk(valid === 1'b0, "R11 valid cleared on bad signature", 256'(valid), 256'(0));

    // bad signature, complete subset
    launch(2'b00);
    wait_idle();
    check_all("R9 bad signature complete subset");
    chk(hub[15:0] == 16'h0424 && hub[31:16] == 16'h9512, "R9 vendor and product defaults",
        256'(hub[31:0]), 256'(32'h9512_0424));

    // good signature again, kind 11
    rom[0] = 8'hA5;
    launch(2'b11);
    wait_idle();
    check_all("R8 kind 11 Ethernet load");
    check_addrs("R8 kind 11 reads");

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule